// File: doc/BRIEF.md
# Flash Embedded-Operation Status Engine

This block is a synthesizable, scaled-down model of the control section of a NOR flash device. It sits behind a chip-select, read-strobe and write-strobe bus, and the strobes are sampled on a system clock. A small register-based word array is held inside the block. Software issues single-word commands to program a word, to erase a chosen set of sectors or the whole array, and to suspend or resume an erase. It can also mark a sector as write-locked.

While a program or an erase runs, the block stands in for the timed pulse-and-verify algorithm. It counts a parameterised number of clock cycles and reports progress in three ways:
- A polling word on the data bus. Bit 7 reads as the inverse of its final value. Bit 6 flips between successive read cycles.
- A ready/busy output.
- An automatic return to read mode when the operation finishes.

An erase first clears every targeted word to zero and then sets the whole target to all ones. A suspended erase lets the host read the sectors that are not being erased.

Top module: `flash_status_engine`

## Requirements
- R1: The data bus is driven (`dq_oe`=1) only while `ce_n`=0, `oe_n`=0 and `we_n`=1. In standby (`ce_n`=1), output-disable (`oe_n`=1, `we_n`=1) and write (`oe_n`=1, `we_n`=0) cycles `dq_oe` is 0.
- R2: In read mode a read cycle returns the array word at `addr`. After reset every word reads all ones.
- R3: Writing data 0xA0 arms a program. The next write latches `addr` and `dq_in`. When the program finishes, the word becomes its old value AND the written data, so programming only clears bits.
- R4: `ry_by` is 0 for exactly PROG_CYC clock cycles after the programming write. For an erase it is 0 for DEPTH+ERASE_CYC cycles after the start write, where DEPTH is 2^AW.
- R5: A read during a program returns the inverse of the programmed data's bit 7 on bit 7. A read during an erase returns 0 on bit 7. Bits 5..0 read 0 while busy.
- R6: While busy, bit 6 of successive read cycles alternates. Once the operation ends, reads return array data and repeated reads are equal.
- R7: When an operation ends, the block returns to read mode by itself. Writes made while a program is busy are ignored, so a later plain write does not program anything.
- R8: Sector erase works as follows. Write 0x80. Then write 0x30 once at an address inside each sector to erase; the sector is the top log2(SECTORS) address bits. Then write 0x10 to start. Only the marked sectors become all ones, after their words are first cleared to zero.
- R9: Writing 0x80 and then 0x10 with no sector marked erases every sector.
- R10: Writing 0xB0 during an erase suspends it and `ry_by` goes to 1. Reads of unmarked sectors then return array data. Reads of a marked sector return bit 7 = 0, a frozen bit 6 and zero on the other bits. Writing 0x30 resumes the erase, which then completes.
- R11: Writing 0x60 at an address locks that address's sector. A program or erase aimed at a locked sector still runs its full busy time but leaves the sector's words unchanged.
- R12: Driving `rst_n` low at once sets `dq_oe` to 0 and `ry_by` to 1 and aborts any operation. On release the block is in read mode with the array at all ones and all locks cleared.
- R13: Writing 0xF0 after 0x80 cancels the erase setup. `ry_by` stays 1 and no data changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bus strobes and the engine |
| rst_n | input | 1 | Active-low asynchronous reset / abort |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data and command codes |
| dq_out | output | DW | Read data or polling word |
| dq_oe | output | 1 | Data bus drive enable |
| ry_by | output | 1 | 1 = ready, 0 = embedded operation running |

## Verification
The bench builds the block with AW=4 and SECTORS=4, which gives sixteen words in four sectors of four. It uses PROG_CYC=8 and ERASE_CYC=40. With these values every word can be read back after each erase. A program lasts long enough for two polling reads to fit inside it. An erase lasts long enough that a suspend always lands inside it. Because the sectors are small, mixed marked, unmarked and locked sectors can all be checked in a single erase.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        ST_READ      = 3'd0,
        ST_PROG_ARM  = 3'd1,
        ST_ERS_SETUP = 3'd2,
        ST_PROG_BUSY = 3'd3,
        ST_ERS_PRE   = 3'd4,
        ST_ERS_WAIT  = 3'd5,
        ST_ERS_SUSP  = 3'd6
    } eng_state_e;

    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERS     = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_GO      = 8'h10;
    localparam logic [7:0] CMD_CANCEL  = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_LOCK    = 8'h60;

    function automatic logic is_busy(input eng_state_e s);
        return (s == ST_PROG_BUSY) || (s == ST_ERS_PRE) || (s == ST_ERS_WAIT);
    endfunction

endpackage

// File: rtl/fl_bus_decode.sv
module fl_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_now,
    output logic rd_end,
    output logic wr_pulse
);
    typedef struct packed {
        logic rd;
        logic wr;
    } dec_t;

    dec_t dec_d, dec_q;
    logic wr_now;

    always_comb begin
        rd_now   = !ce_n && !oe_n && we_n;
        wr_now   = !ce_n && oe_n && !we_n;
        dec_d.rd = rd_now;
        dec_d.wr = wr_now;
        rd_end   = dec_q.rd && !rd_now;
        wr_pulse = wr_now && !dec_q.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    // a bus cycle cannot be both a read and a write
    always_comb begin
        if (rst_n) AST_RD_WR_EXCL: assert (!(rd_now && wr_pulse)); // R1
    end
endmodule

// File: rtl/fl_read_mux.sv
module fl_read_mux #(
    parameter int DW      = 8,
    parameter int AW      = 6,
    parameter int SECTORS = 4,
    localparam int DEPTH  = 1 << AW,
    localparam int SW     = $clog2(SECTORS)
) (
    input  logic                      rst_n,
    input  logic                      rd_now,
    input  logic                      busy,
    input  logic                      susp,
    input  logic                      poll_bit7,
    input  logic                      tog,
    input  logic [SECTORS-1:0]        ers_mask,
    input  logic [DEPTH-1:0][DW-1:0]  mem,
    input  logic [AW-1:0]             addr,
    output logic [DW-1:0]             dq_out,
    output logic                      dq_oe
);
    logic [SW-1:0] sec;

    always_comb begin
        sec    = addr[AW-1 -: SW];
        dq_out = '0;
        if (busy) begin
            dq_out[7] = poll_bit7;
            dq_out[6] = tog;
        end else if (susp && ers_mask[sec]) begin
            dq_out[6] = tog;
        end else begin
            dq_out = mem[addr];
        end
        dq_oe = rd_now && rst_n;
    end
endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
    import flash_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 6,
    parameter int SECTORS   = 4,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          ry_by
);
    localparam int DEPTH = 1 << AW;
    localparam int SW    = $clog2(SECTORS);
    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    typedef struct packed {
        eng_state_e                st;
        logic [DEPTH-1:0][DW-1:0]  mem;
        logic [SECTORS-1:0]        lock;
        logic [SECTORS-1:0]        mark;
        logic [AW-1:0]             op_addr;
        logic [DW-1:0]             op_data;
        logic [CW-1:0]             cnt;
        logic [AW-1:0]             idx;
        logic                      tog;
        logic                      susp_wait;
    } eng_t;

    eng_t eng_d, eng_q;
    logic rd_now, rd_end, wr_pulse, busy;
    logic [7:0] cmd;

    function automatic logic [SW-1:0] sec_of(input logic [AW-1:0] a);
        return a[AW-1 -: SW];
    endfunction

    fl_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_now(rd_now), .rd_end(rd_end), .wr_pulse(wr_pulse)
    );

    always_comb begin
        eng_d = eng_q;
        busy  = is_busy(eng_q.st);
        cmd   = dq_in[7:0];
        if (rd_end && busy) eng_d.tog = !eng_q.tog;
        case (eng_q.st)
            ST_READ: if (wr_pulse) begin
                if (cmd == CMD_PROG) eng_d.st = ST_PROG_ARM;
                else if (cmd == CMD_ERS) begin
                    eng_d.st   = ST_ERS_SETUP;
                    eng_d.mark = '0;
                end else if (cmd == CMD_LOCK) eng_d.lock[sec_of(addr)] = 1'b1;
            end
            ST_PROG_ARM: if (wr_pulse) begin
                eng_d.op_addr = addr;
                eng_d.op_data = dq_in;
                eng_d.cnt     = CW'(PROG_CYC - 1);
                eng_d.st      = ST_PROG_BUSY;
            end
            ST_ERS_SETUP: if (wr_pulse) begin
                if (cmd == CMD_SECTOR) eng_d.mark[sec_of(addr)] = 1'b1;
                else if (cmd == CMD_GO) begin
                    eng_d.mark = ((eng_q.mark == '0) ? '1 : eng_q.mark) & ~eng_q.lock;
                    eng_d.idx  = '0;
                    eng_d.st   = ST_ERS_PRE;
                end else if (cmd == CMD_CANCEL) begin
                    eng_d.mark = '0;
                    eng_d.st   = ST_READ;
                end
            end
            ST_PROG_BUSY: begin
                if (eng_q.cnt == '0) begin
                    if (!eng_q.lock[sec_of(eng_q.op_addr)])
                        eng_d.mem[eng_q.op_addr] = eng_q.mem[eng_q.op_addr] & eng_q.op_data;
                    eng_d.st = ST_READ;
                end else eng_d.cnt = eng_q.cnt - 1'b1;
            end
            ST_ERS_PRE: begin
                if (wr_pulse && cmd == CMD_SUSPEND) begin
                    eng_d.st        = ST_ERS_SUSP;
                    eng_d.susp_wait = 1'b0;
                end else begin
                    if (eng_q.mark[sec_of(eng_q.idx)]) eng_d.mem[eng_q.idx] = '0;
                    if (eng_q.idx == AW'(DEPTH - 1)) begin
                        eng_d.cnt = CW'(ERASE_CYC - 1);
                        eng_d.st  = ST_ERS_WAIT;
                    end else eng_d.idx = eng_q.idx + 1'b1;
                end
            end
            ST_ERS_WAIT: begin
                if (wr_pulse && cmd == CMD_SUSPEND) begin
                    eng_d.st        = ST_ERS_SUSP;
                    eng_d.susp_wait = 1'b1;
                end else if (eng_q.cnt == '0) begin
                    for (int i = 0; i < DEPTH; i++)
                        if (eng_q.mark[sec_of(AW'(i))]) eng_d.mem[i] = '1;
                    eng_d.mark = '0;
                    eng_d.st   = ST_READ;
                end else eng_d.cnt = eng_q.cnt - 1'b1;
            end
            ST_ERS_SUSP: if (wr_pulse && cmd == CMD_SECTOR)
                eng_d.st = eng_q.susp_wait ? ST_ERS_WAIT : ST_ERS_PRE;
            default: eng_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q     <= '0;
            eng_q.mem <= '1;
        end else eng_q <= eng_d;
    end

    fl_read_mux #(.DW(DW), .AW(AW), .SECTORS(SECTORS)) u_mux (
        .rst_n(rst_n), .rd_now(rd_now), .busy(busy),
        .susp(eng_q.st == ST_ERS_SUSP),
        .poll_bit7((eng_q.st == ST_PROG_BUSY) ? !eng_q.op_data[7] : 1'b0),
        .tog(eng_q.tog), .ers_mask(eng_q.mark), .mem(eng_q.mem), .addr(addr),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    assign ry_by = !busy;

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_PROG_BUSY) |=> ((eng_q.mem & ~$past(eng_q.mem)) == '0)); // R3
    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_PROG_BUSY && eng_q.lock[sec_of(eng_q.op_addr)]) |=> $stable(eng_q.mem)); // R11
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_PROG_BUSY && eng_q.cnt == '0) |=> ry_by); // R7
    AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && busy) |=> (eng_q.tog != $past(eng_q.tog))); // R6
    AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_ERS_SUSP) |=> ($stable(eng_q.mem) && $stable(eng_q.cnt))); // R10
    always_comb begin
        if (dq_oe) AST_DRIVE_ON_READ: assert (!ce_n && !oe_n && we_n && rst_n); // R1
    end
endmodule

// File: tb/sim_flash_status_engine.sv
module sim_flash_status_engine;
    localparam int PC = 8;
    localparam int EC = 40;
    localparam int ND = 16;

    logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic dq_oe, ry_by;
    int n_chk = 0, n_bad = 0;
    logic [7:0] rm [ND];
    logic [3:0] rlock;

    always #2 clk = !clk;

    flash_status_engine #(.DW(8), .AW(4), .SECTORS(4), .PROG_CYC(PC), .ERASE_CYC(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by)
    );

    function automatic logic [1:0] sec(input logic [3:0] a);
        return a[3:2];
    endfunction

    function automatic logic [7:0] prog_val(input logic [7:0] old, input logic [7:0] d, input logic lk);
        return lk ? old : (old & d);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; dq_in = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1 d = dq_out;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ry_by) begin n++; @(negedge clk); end
    endtask

    task automatic ref_reset();
        for (int i = 0; i < ND; i++) rm[i] = 8'hFF;
        rlock = '0;
    endtask

    task automatic ref_erase(input logic [3:0] m);
        for (int i = 0; i < ND; i++)
            if (m[sec(4'(i))] && !rlock[sec(4'(i))]) rm[i] = 8'hFF;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] r;
        for (int i = 0; i < ND; i++) begin
            bus_read(4'(i), r);
            chk(tag, r, rm[i]);
        end
    endtask

    task automatic program_word(input logic [3:0] a, input logic [7:0] d, input string tag);
        int n;
        bus_write(4'h0, 8'hA0);
        bus_write(a, d);
        busy_len(n);
        chk(tag, n, PC);
        rm[a] = prog_val(rm[a], d, rlock[sec(a)]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r, r2;
        int n;
        void'($urandom(32'd4711));
        ref_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ready after reset", ry_by, 1);

        // R1 cycle-type decode
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; #1 chk("R1 standby", dq_oe, 0);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1 chk("R1 output disable", dq_oe, 0);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; #1 chk("R1 read drives", dq_oe, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; #1 chk("R1 write no drive", dq_oe, 0);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);

        check_all("R2 reset array");

        // R3 R4 random programs
        for (int k = 0; k < 40; k++) begin
            logic [3:0] a;
            logic [7:0] d;
            a = 4'($urandom % ND);
            d = 8'($urandom);
            program_word(a, d, "R4 program busy");
            bus_read(a, r);
            chk("R3 program result", r, rm[a]);
        end
        check_all("R3 array after programs");

        // R5 R6 polling during program
        bus_write(4'h0, 8'hA0);
        bus_write(4'h2, 8'h3C);
        bus_read(4'h2, r);
        bus_read(4'h2, r2);
        chk("R5 dq7 inverse", r[7], 1);
        chk("R5 low bits zero", r & 8'h3F, 0);
        chk("R6 dq6 alternates", r ^ r2, 8'h40);
        while (!ry_by) @(negedge clk);
        rm[2] = rm[2] & 8'h3C;
        bus_read(4'h2, r);
        bus_read(4'h2, r2);
        chk("R6 done data", r, rm[2]);
        chk("R6 stable after done", r2, r);

        // R7 writes during busy ignored
        bus_write(4'h0, 8'hA0);
        bus_write(4'h5, 8'hF7);
        bus_write(4'h0, 8'hA0);
        while (!ry_by) @(negedge clk);
        rm[5] = rm[5] & 8'hF7;
        chk("R7 back to read", ry_by, 1);
        bus_write(4'h6, 8'h00);
        @(negedge clk);
        bus_read(4'h6, r);
        chk("R7 no stray program", r, rm[6]);

        // R13 cancel erase setup
        bus_write(4'h0, 8'h80);
        bus_write(4'h4, 8'h30);
        bus_write(4'h0, 8'hF0);
        @(negedge clk);
        chk("R13 stays ready", ry_by, 1);
        check_all("R13 data kept");

        // R8 R4 sector erase of sectors 1 and 3
        bus_write(4'h0, 8'h80);
        bus_write(4'h4, 8'h30);
        bus_write(4'hC, 8'h30);
        bus_write(4'h0, 8'h10);
        busy_len(n);
        chk("R4 erase busy", n, ND + EC);
        ref_erase(4'b1010);
        check_all("R8 sector erase");

        // R9 R5 R6 chip erase with polling
        program_word(4'h1, 8'h81, "R4 program busy");
        bus_write(4'h0, 8'h80);
        bus_write(4'h0, 8'h10);
        bus_read(4'h1, r);
        bus_read(4'h1, r2);
        chk("R5 erase dq7 zero", r[7], 0);
        chk("R6 erase toggle", r ^ r2, 8'h40);
        while (!ry_by) @(negedge clk);
        ref_erase(4'b1111);
        check_all("R9 chip erase");

        // R11 lock sector 2
        program_word(4'h8, 8'h12, "R4 program busy");
        bus_write(4'h9, 8'h60);
        rlock[2] = 1'b1;
        program_word(4'h9, 8'h00, "R11 locked program busy");
        bus_read(4'h9, r);
        chk("R11 locked program", r, 8'hFF);
        program_word(4'h0, 8'h0F, "R4 program busy");
        program_word(4'hD, 8'h44, "R4 program busy");
        bus_write(4'h0, 8'h80);
        bus_write(4'h0, 8'h10);
        while (!ry_by) @(negedge clk);
        ref_erase(4'b1111);
        check_all("R11 locked erase");

        // R10 suspend / resume: erase sector 1, read sector 0
        program_word(4'h0, 8'h5A, "R4 program busy");
        program_word(4'h5, 8'h00, "R4 program busy");
        bus_write(4'h0, 8'h80);
        bus_write(4'h4, 8'h30);
        bus_write(4'h0, 8'h10);
        repeat (20) @(negedge clk);
        bus_write(4'h0, 8'hB0);
        @(negedge clk);
        chk("R10 ready in suspend", ry_by, 1);
        bus_read(4'h0, r);
        chk("R10 other sector readable", r, rm[0]);
        bus_read(4'h5, r);
        bus_read(4'h5, r2);
        chk("R10 target status", r & 8'hBF, 0);
        chk("R10 frozen toggle", r2, r);
        bus_write(4'h0, 8'h30);
        @(negedge clk);
        chk("R10 busy on resume", ry_by, 0);
        while (!ry_by) @(negedge clk);
        ref_erase(4'b0010);
        check_all("R10 erase done");

        // R12 reset during erase
        program_word(4'h3, 8'h21, "R4 program busy");
        bus_write(4'h0, 8'h80);
        bus_write(4'h0, 8'h10);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        rst_n = 1'b0;
        #1 chk("R12 hiz in reset", dq_oe, 0);
        chk("R12 ready in reset", ry_by, 1);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        check_all("R12 array after reset");
        program_word(4'h9, 8'h0C, "R12 lock cleared busy");
        bus_read(4'h9, r);
        chk("R12 lock cleared", r, 8'h0C);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule